// File: doc/BRIEF.md
# Double-Buffered PWM Channel

A single pulse-width modulation channel controlled through a small register bank. The counting clock is the base clock divided by a selectable power of two, or one of two externally supplied tick strobes. The channel's counter runs either as a left-aligned sawtooth or as a center-aligned triangle. The output sits at its idle level, chosen by a polarity bit, whenever it is not in its active phase.

While the channel runs, the period, duty and mode registers cannot be written directly. New period or duty values go through an update register that holds the value as pending. The pending value is applied at the next period boundary, which is the tick where the counter returns to zero. A mode bit chooses whether the pending value replaces the period or the duty. Each boundary sets an interrupt flag, so software knows when it may supply the next value. Reading the update address returns the flag and clears it.

The register interface is a plain single-cycle bus: write strobe, read strobe, byte address and data. Read data is combinational from the address, so there is no handshake and no back-pressure.

Top module: `pwm_dbuf_chan`

## Requirements
- R1: Byte offsets decode as follows: 0x00 is mode, 0x04 is duty, 0x08 is period, 0x0C is the counter (read-only) and 0x10 is update. The mode register reads back as bit 10 (update target), bit 9 (idle level), bit 8 (center alignment) and bits 3:0 (clock code), with every other bit reading 0. Writes to mode, duty and period take effect only while the channel is disabled and are ignored while it runs.
- R2: While `chan_en` is low, the counter is 0 and `pwm_out` equals mode bit 9.
- R3: Clock code N from 0 to 10 advances the counter once every 2^N base cycles. With N=0 the first advance is on the second rising edge after `chan_en` is seen high. Code 0xB advances the counter on each cycle where `ext_tick_a` is high, and code 0xC does the same with `ext_tick_b`. Codes 0xD to 0xF never advance the counter.
- R4: With mode bit 8 clear, the counter runs 0, 1, ..., P-1 and then returns to 0, where P is the period value. A period of 0 behaves as 1.
- R5: With mode bit 8 set, the counter runs up from 0 to P and back down to 0, so one cycle lasts 2P ticks.
- R6: While running, the output is at its active level (the inverse of mode bit 9) when the counter is below the duty value, and at the idle level otherwise.
- R7: A write to 0x10 while running is held pending and applied when the counter next returns to 0. If mode bit 10 is 1 the value goes to the period, and if it is 0 it goes to the duty. A write to 0x10 while disabled is applied at once.
- R8: Every period boundary sets the interrupt flag, which drives `irq`. A read strobe at 0x10 returns the flag in bit 0 and clears it. A boundary in the same cycle as the read wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable |
| ext_tick_a | input | 1 | External divided clock strobe A |
| ext_tick_b | input | 1 | External divided clock strobe B |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the flag at 0x10) |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| pwm_out | output | 1 | PWM waveform |
| irq | output | 1 | Once-per-period interrupt flag |

## Verification
The waveform is compared cycle by cycle against a model for a left-aligned low-idle pattern, a center-aligned high-idle pattern and two divided rates. These patterns separate errors in the counter shape, the compare and the polarity, and they show a wrong prescale tap as a stretched waveform. External strobes are pulsed while the other strobe is held high, which shows a swapped clock selection. An unused code confirms that the counter stalls. Duty and period updates are read back one cycle before and one cycle at the boundary, which separates an update applied at once from one applied at the boundary. A direct duty write while running shows whether the lock holds.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int MODE_UPD_BIT = 10;
  localparam int MODE_POL_BIT = 9;
  localparam int MODE_CTR_BIT = 8;
  localparam logic [3:0] CODE_EXT_A = 4'hB;
  localparam logic [3:0] CODE_EXT_B = 4'hC;

  localparam logic [7:0] OFF_MODE = 8'h00;
  localparam logic [7:0] OFF_DUTY = 8'h04;
  localparam logic [7:0] OFF_PRD  = 8'h08;
  localparam logic [7:0] OFF_CNT  = 8'h0C;
  localparam logic [7:0] OFF_UPD  = 8'h10;

  typedef struct packed {
    logic       upd_prd;
    logic       idle_hi;
    logic       center;
    logic [3:0] clk_sel;
  } mode_t;
endpackage

// File: rtl/pwm_tick_sel.sv
module pwm_tick_sel #(
  parameter int MAX_DIV = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] clk_sel,
  input  logic       ext_a,
  input  logic       ext_b,
  output logic       tick
);
  import pwm_pkg::*;
  localparam int DIV_W = MAX_DIV;

  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W:0]   full_mask;
  logic [DIV_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) div_cnt <= '0;
    else                div_cnt <= div_cnt + 1'b1;
  end

  always_comb begin
    full_mask = ({{DIV_W{1'b0}}, 1'b1} << clk_sel) - 1'b1;
    mask      = full_mask[DIV_W-1:0];
    tick      = 1'b0;
    if (run) begin
      if (32'(clk_sel) <= MAX_DIV) tick = &(div_cnt | ~mask);
      else if (clk_sel == CODE_EXT_A) tick = ext_a;
      else if (clk_sel == CODE_EXT_B) tick = ext_b;
    end
  end

  AST_DIV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> div_cnt == '0) else $error("divider not cleared"); // R3
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             center,
  input  logic             idle_hi,
  input  logic [CNT_W-1:0] prd,
  input  logic [CNT_W-1:0] duty,
  output logic [CNT_W-1:0] cnt,
  output logic             boundary,
  output logic             pwm_out
);
  logic             down;
  logic [CNT_W-1:0] prd_eff;
  logic [CNT_W:0]   cnt_inc;

  assign prd_eff = (prd == '0) ? CNT_W'(1) : prd;
  assign cnt_inc = {1'b0, cnt} + 1'b1;

  always_comb begin
    boundary = 1'b0;
    if (run && tick) begin
      if (center) boundary = down && (cnt <= CNT_W'(1));
      else        boundary = (cnt >= prd_eff - 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (tick) begin
      if (center) begin
        if (!down) begin
          cnt <= cnt_inc[CNT_W-1:0];
          if (cnt_inc >= {1'b0, prd_eff}) down <= 1'b1;
        end else if (cnt <= CNT_W'(1)) begin
          cnt  <= '0;
          down <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else begin
        cnt <= boundary ? '0 : cnt_inc[CNT_W-1:0];
      end
    end
  end

  assign pwm_out = run ? ((cnt < duty) ^ idle_hi) : idle_hi;

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0) else $error("counter not cleared"); // R2
  AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run && !center |-> cnt < prd_eff) else $error("left count out of range"); // R4
  AST_CENTER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run && center |-> cnt <= prd_eff) else $error("center count out of range"); // R5
  AST_DOWN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run && center && down |-> cnt != '0) else $error("down at zero"); // R5
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int CNT_W  = 20,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              boundary,
  output pwm_pkg::mode_t    mode,
  output logic [CNT_W-1:0]  prd,
  output logic [CNT_W-1:0]  duty,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  import pwm_pkg::*;

  logic [CNT_W-1:0] pend_val;
  logic             pend_q;
  logic             hit_mode, hit_duty, hit_prd, hit_cnt, hit_upd;
  logic             unused_bits;

  assign hit_mode = addr == ADDR_W'(OFF_MODE);
  assign hit_duty = addr == ADDR_W'(OFF_DUTY);
  assign hit_prd  = addr == ADDR_W'(OFF_PRD);
  assign hit_cnt  = addr == ADDR_W'(OFF_CNT);
  assign hit_upd  = addr == ADDR_W'(OFF_UPD);
  assign unused_bits = ^{wdata[DATA_W-1:CNT_W], wdata[7:4]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= '0;
      prd      <= '0;
      duty     <= '0;
      pend_val <= '0;
      pend_q   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (!run) begin
        pend_q <= 1'b0;
        if (wr) begin
          if (hit_mode) begin
            mode.upd_prd <= wdata[MODE_UPD_BIT];
            mode.idle_hi <= wdata[MODE_POL_BIT];
            mode.center  <= wdata[MODE_CTR_BIT];
            mode.clk_sel <= wdata[3:0];
          end
          if (hit_duty) duty <= wdata[CNT_W-1:0];
          if (hit_prd)  prd  <= wdata[CNT_W-1:0];
          if (hit_upd) begin
            if (mode.upd_prd) prd  <= wdata[CNT_W-1:0];
            else              duty <= wdata[CNT_W-1:0];
          end
        end
      end else begin
        if (boundary && pend_q) begin
          if (mode.upd_prd) prd  <= pend_val;
          else              duty <= pend_val;
          pend_q <= 1'b0;
        end
        if (wr && hit_upd) begin
          pend_val <= wdata[CNT_W-1:0];
          pend_q   <= 1'b1;
        end
      end
      if (boundary)            irq <= 1'b1;
      else if (rd && hit_upd)  irq <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_mode) rdata = DATA_W'({mode.upd_prd, mode.idle_hi, mode.center, 4'b0000, mode.clk_sel});
    if (hit_duty) rdata = DATA_W'(duty);
    if (hit_prd)  rdata = DATA_W'(prd);
    if (hit_cnt)  rdata = DATA_W'(cnt);
    if (hit_upd)  rdata = DATA_W'(irq);
  end

  AST_LOCK_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    run && !boundary |=> $stable(duty) && $stable(prd) && $stable(mode)) else $error("register changed mid-period"); // R1
  AST_PEND_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    run && boundary && pend_q && !(wr && hit_upd) |=> !pend_q) else $error("pending value not applied"); // R7
  AST_IRQ_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> irq) else $error("boundary without flag"); // R8
endmodule

// File: rtl/pwm_dbuf_chan.sv
module pwm_dbuf_chan #(
  parameter int CNT_W   = 20,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  parameter int MAX_DIV = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              ext_tick_a,
  input  logic              ext_tick_b,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwm_out,
  output logic              irq
);
  import pwm_pkg::*;

  logic             run_q;
  logic             tick;
  logic             boundary;
  mode_t            mode;
  logic [CNT_W-1:0] prd, duty, cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= chan_en;
  end

  pwm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .run(run_q), .wr(reg_wr), .rd(reg_rd),
    .addr(reg_addr), .wdata(reg_wdata), .cnt(cnt), .boundary(boundary),
    .mode(mode), .prd(prd), .duty(duty), .rdata(reg_rdata), .irq(irq)
  );

  pwm_tick_sel #(.MAX_DIV(MAX_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run_q), .clk_sel(mode.clk_sel),
    .ext_a(ext_tick_a), .ext_b(ext_tick_b), .tick(tick)
  );

  pwm_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick),
    .center(mode.center), .idle_hi(mode.idle_hi), .prd(prd), .duty(duty),
    .cnt(cnt), .boundary(boundary), .pwm_out(pwm_out)
  );

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> pwm_out == mode.idle_hi) else $error("output not idle"); // R2
endmodule

// File: tb/pwm_dbuf_chan_bench.sv
module pwm_dbuf_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en = 1'b0;
  logic        ext_tick_a = 1'b0;
  logic        ext_tick_b = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pwm_out;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  typedef struct { logic v; string tag; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  pwm_dbuf_chan u_pwm_dbuf_chan (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .ext_tick_a(ext_tick_a),
    .ext_tick_b(ext_tick_b), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwm_out(pwm_out), .irq(irq)
  );

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(e.tag, longint'(pwm_out), longint'(e.v));
    end
  end

  function automatic logic [31:0] mode_word(bit upd, bit pol, bit ctr, logic [3:0] code);
    return (32'(upd) << 10) | (32'(pol) << 9) | (32'(ctr) << 8) | 32'(code);
  endfunction

  function automatic logic exp_out(int j, int prd, int duty, bit pol, bit ctr, int shift);
    int t, p, c, ph;
    t = j >> shift;
    p = (prd == 0) ? 1 : prd;
    if (!ctr) c = t % p;
    else begin
      ph = t % (2 * p);
      c = (ph <= p) ? ph : 2 * p - ph;
    end
    return (c < duty) ? logic'(!pol) : logic'(pol);
  endfunction

  task automatic bus_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic read_clear(output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 5'h10;
    #1;
    d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic stop_chan();
    @(negedge clk);
    chan_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // driver: configure, push expected samples, then run until the monitor drains them
  task automatic run_wave(int prd, int duty, bit pol, bit ctr, logic [3:0] code, int shift, int n, string tag);
    bus_write(5'h00, mode_word(1'b0, pol, ctr, code));
    bus_write(5'h04, 32'(duty));
    bus_write(5'h08, 32'(prd));
    for (int j = 0; j < n; j++) begin
      exp_t e;
      e.v = exp_out(j, prd, duty, pol, ctr, shift);
      e.tag = tag;
      exp_q.push_back(e);
    end
    @(negedge clk);
    chan_en = 1'b1;
    @(posedge clk);
    mon_on = 1'b1;
    while (exp_q.size() > 0) @(negedge clk);
    mon_on = 1'b0;
    stop_chan();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    peek(5'h00, d); chk("R1 mode after reset", d, 0);
    peek(5'h0C, d); chk("R2 counter after reset", d, 0);
    chk("R2 idle output after reset", pwm_out, 0);
    chk("R8 irq after reset", irq, 0);

    // mode readback hides bits 7:4
    bus_write(5'h00, 32'h0000_07FB);
    peek(5'h00, d); chk("R1 mode readback", d, 32'h0000_070B);
    chk("R2 idle high while disabled", pwm_out, 1);
    bus_write(5'h00, 32'h0);
    bus_write(5'h04, 32'd2); peek(5'h04, d); chk("R1 duty readback", d, 2);
    bus_write(5'h08, 32'd5); peek(5'h08, d); chk("R1 period readback", d, 5);

    // waveforms
    run_wave(5, 2, 1'b0, 1'b0, 4'h0, 0, 20, "R4 R6 left low-idle");
    run_wave(3, 1, 1'b1, 1'b1, 4'h0, 0, 18, "R5 R6 center high-idle");
    chk("R2 idle high after stop", pwm_out, 1);
    peek(5'h0C, d); chk("R2 counter zero after stop", d, 0);
    run_wave(3, 1, 1'b0, 1'b0, 4'h1, 1, 24, "R3 divide by 2");
    run_wave(4, 3, 1'b0, 1'b0, 4'h2, 2, 40, "R3 divide by 4");
    run_wave(0, 1, 1'b0, 1'b0, 4'h0, 0, 6, "R4 zero period");

    // interrupt timing, lock of direct writes
    bus_write(5'h00, mode_word(1'b0, 1'b0, 1'b0, 4'h0));
    bus_write(5'h08, 32'd4);
    bus_write(5'h04, 32'd1);
    read_clear(d);
    @(negedge clk); chk("R8 flag cleared by read", irq, 0);
    chan_en = 1'b1;                                   // edge E next
    @(negedge clk);                                   // after E
    reg_wr = 1'b1; reg_addr = 5'h04; reg_wdata = 32'd3;
    @(negedge clk);                                   // after E+1
    reg_wr = 1'b0;
    peek(5'h04, d); chk("R1 duty write ignored while running", d, 1);
    @(negedge clk);                                   // after E+2
    peek(5'h0C, d); chk("R4 counter mid-period", d, 2);
    @(negedge clk);                                   // after E+3
    chk("R8 no flag before boundary", irq, 0);
    @(negedge clk);                                   // after E+4
    chk("R8 flag at boundary", irq, 1);
    stop_chan();
    read_clear(d); chk("R8 flag read value", d, 1);
    read_clear(d); chk("R8 flag cleared", d, 0);

    // duty update through the buffer
    bus_write(5'h00, mode_word(1'b0, 1'b0, 1'b0, 4'h0));
    @(negedge clk); chan_en = 1'b1;                   // E
    @(negedge clk);                                   // after E
    reg_wr = 1'b1; reg_addr = 5'h10; reg_wdata = 32'd3;
    @(negedge clk); reg_wr = 1'b0;                    // after E+1
    peek(5'h04, d); chk("R7 duty pending", d, 1);
    @(negedge clk); @(negedge clk);                   // after E+3
    peek(5'h04, d); chk("R7 duty before boundary", d, 1);
    @(negedge clk);                                   // after E+4
    peek(5'h04, d); chk("R7 duty applied at boundary", d, 3);
    stop_chan();

    // period update through the buffer
    bus_write(5'h00, mode_word(1'b1, 1'b0, 1'b0, 4'h0));
    @(negedge clk); chan_en = 1'b1;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'h10; reg_wdata = 32'd6;
    @(negedge clk); reg_wr = 1'b0;
    @(negedge clk); @(negedge clk);                   // after E+3
    peek(5'h08, d); chk("R7 period before boundary", d, 4);
    @(negedge clk);                                   // after E+4
    peek(5'h08, d); chk("R7 period applied at boundary", d, 6);
    peek(5'h04, d); chk("R7 duty untouched by period update", d, 3);
    stop_chan();

    // update while disabled applies at once
    bus_write(5'h10, 32'd9);
    peek(5'h08, d); chk("R7 update while disabled", d, 9);

    // external strobes
    bus_write(5'h08, 32'd100);
    bus_write(5'h00, mode_word(1'b0, 1'b0, 1'b0, 4'hB));
    @(negedge clk); chan_en = 1'b1; ext_tick_b = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      ext_tick_a = 1'b1; @(negedge clk);
      ext_tick_a = 1'b0; @(negedge clk);
    end
    peek(5'h0C, d); chk("R3 strobe A count", d, 3);
    ext_tick_b = 1'b0;
    stop_chan();
    bus_write(5'h00, mode_word(1'b0, 1'b0, 1'b0, 4'hC));
    @(negedge clk); chan_en = 1'b1; ext_tick_a = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      ext_tick_b = 1'b1; @(negedge clk);
      ext_tick_b = 1'b0; @(negedge clk);
    end
    peek(5'h0C, d); chk("R3 strobe B count", d, 2);
    stop_chan();
    bus_write(5'h00, mode_word(1'b0, 1'b0, 1'b0, 4'hD));
    @(negedge clk); chan_en = 1'b1; ext_tick_b = 1'b1;
    repeat (6) @(negedge clk);
    peek(5'h0C, d); chk("R3 unused code stalls", d, 0);
    ext_tick_a = 1'b0; ext_tick_b = 1'b0;
    stop_chan();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule